// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block computes the effective data address for the load and store addressing forms of a small 8-bit processor core. It selects one of three 16-bit pointers held in the top six general registers, or takes an absolute address from the instruction. It then forms the access address and, for the self-modifying forms, the new pointer value that the register file must store back.

One request is presented with a one-cycle `start` strobe. One clock later the unit shows a `done` pulse together with the registered effective address, the writeback value, the writeback enable, the pointer that the writeback targets and an `illegal` flag. Instruction decoding and the timing of the memory access belong to the surrounding pipeline.

Top module: `agu_ptr_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done`, `wb_en`, `illegal`, `eff_addr`, `wb_data` and `wb_sel` are all zero.
- R2: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise. All result outputs update only on a start.
- R3: `gpr_hi` packs six registers, where byte k (bits 8k+7:8k) is register 26+k. Select code 0 is X = {byte1, byte0}, code 1 is Y = {byte3, byte2} and code 2 is Z = {byte5, byte4}. Indirect mode (code 1) gives `eff_addr` = the selected pointer and `wb_en` = 0.
- R4: Direct mode (code 0) gives `eff_addr` = `direct_addr` for any `ptr_sel`, with `wb_en` = 0 and `illegal` = 0.
- R5: Displacement mode (code 2) with Y or Z gives `eff_addr` = pointer + zero-extended `disp` (0 to 63), with `wb_en` = 0.
- R6: Pre-decrement mode (code 3) gives `eff_addr` = `wb_data` = pointer − 1, `wb_en` = 1 and `wb_sel` = `ptr_sel`.
- R7: Post-increment mode (code 4) gives `eff_addr` = pointer, `wb_data` = pointer + 1, `wb_en` = 1 and `wb_sel` = `ptr_sel`.
- R8: All pointer arithmetic wraps modulo 2^16. Pre-decrement of 0x0000 gives 0xFFFF, post-increment of 0xFFFF gives 0x0000, and displacement sums above 0xFFFF wrap.
- R9: A request is illegal in three cases: displacement mode with X, a pointer mode with select code 3, or a mode code from 5 to 7. An illegal request gives `illegal` = 1, `wb_en` = 0, `eff_addr` = 0 and `wb_data` = 0.
- R10: `wb_en` is high only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| disp | input | 6 | Displacement, unsigned |
| direct_addr | input | 16 | Absolute address for direct mode |
| gpr_hi | input | 48 | Registers 26..31, byte k = register 26+k |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective data address |
| wb_data | output | 16 | New pointer value |
| wb_en | output | 1 | Pointer writeback enable |
| wb_sel | output | 2 | Pointer that the writeback targets |
| illegal | output | 1 | Request was rejected |

## Verification
Every result is registered once, so a wrong selection, offset or wrap shows up at `eff_addr` or `wb_data` in the very `done` cycle of the request that caused it. A stale or mis-decoded mode shows up as a wrong `wb_en` or `illegal` in that same cycle. The bench sweeps every mode and select code over pointer values at both ends of the range and displacements at both limits. In each case it compares all outputs with values it computes itself. It also checks that idle cycles raise neither `done` nor `wb_en`.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [2:0] AM_DIRECT  = 3'd0;
  localparam logic [2:0] AM_IND     = 3'd1;
  localparam logic [2:0] AM_DISP    = 3'd2;
  localparam logic [2:0] AM_PREDEC  = 3'd3;
  localparam logic [2:0] AM_POSTINC = 3'd4;
  localparam logic [1:0] SEL_X = 2'd0;
  localparam logic [1:0] SEL_Y = 2'd1;
  localparam logic [1:0] SEL_Z = 2'd2;
  localparam int NPTR = 3;
endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [6*DW-1:0] gpr_hi,
  input  logic [1:0]      sel,
  output logic [AW-1:0]   ptr
);
  logic [AW-1:0] pair [agu_pkg::NPTR];

  // pointer p = {register 26+2p+1, register 26+2p}
  for (genvar p = 0; p < agu_pkg::NPTR; p++) begin : g_pair
    assign pair[p] = {gpr_hi[(2*p+1)*DW +: DW], gpr_hi[(2*p)*DW +: DW]};
  end

  always_comb begin
    case (sel)
      agu_pkg::SEL_X: ptr = pair[0];
      agu_pkg::SEL_Y: ptr = pair[1];
      agu_pkg::SEL_Z: ptr = pair[2];
      default:        ptr = '0;
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int DW    = 8,
  parameter int DISPW = 6,
  localparam int AW   = 2 * DW
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       sel,
  input  logic [DISPW-1:0] disp,
  input  logic [AW-1:0]    direct_addr,
  input  logic [AW-1:0]    ptr,
  output logic [AW-1:0]    eff,
  output logic [AW-1:0]    wb,
  output logic             wb_en,
  output logic             bad
);
  import agu_pkg::*;

  logic          uses_ptr;
  logic [AW-1:0] disp_ext;

  assign disp_ext = {{(AW-DISPW){1'b0}}, disp};
  assign uses_ptr = (mode == AM_IND) || (mode == AM_DISP) ||
                    (mode == AM_PREDEC) || (mode == AM_POSTINC);
  assign bad = (mode > AM_POSTINC) ||
               (uses_ptr && (sel > SEL_Z)) ||
               ((mode == AM_DISP) && (sel == SEL_X));

  always_comb begin
    eff   = '0;
    wb    = '0;
    wb_en = 1'b0;
    if (!bad) begin
      case (mode)
        AM_DIRECT: eff = direct_addr;
        AM_IND:    eff = ptr;
        AM_DISP:   eff = ptr + disp_ext;
        AM_PREDEC: begin
          eff   = ptr - 1'b1;
          wb    = ptr - 1'b1;
          wb_en = 1'b1;
        end
        AM_POSTINC: begin
          eff   = ptr;
          wb    = ptr + 1'b1;
          wb_en = 1'b1;
        end
        default: eff = '0;
      endcase
    end
  end
endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit #(
  parameter int DW    = 8,
  parameter int DISPW = 6,
  localparam int AW   = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic [DISPW-1:0] disp,
  input  logic [AW-1:0]    direct_addr,
  input  logic [6*DW-1:0]  gpr_hi,
  output logic             done,
  output logic [AW-1:0]    eff_addr,
  output logic [AW-1:0]    wb_data,
  output logic             wb_en,
  output logic [1:0]       wb_sel,
  output logic             illegal
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] c_eff;
  logic [AW-1:0] c_wb;
  logic          c_wb_en;
  logic          c_bad;

  agu_ptr_mux #(.DW(DW)) u_mux (
    .gpr_hi (gpr_hi),
    .sel    (ptr_sel),
    .ptr    (ptr_q)
  );

  agu_calc #(.DW(DW), .DISPW(DISPW)) u_calc (
    .mode        (mode),
    .sel         (ptr_sel),
    .disp        (disp),
    .direct_addr (direct_addr),
    .ptr         (ptr_q),
    .eff         (c_eff),
    .wb          (c_wb),
    .wb_en       (c_wb_en),
    .bad         (c_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      eff_addr <= '0;
      wb_data  <= '0;
      wb_en    <= 1'b0;
      wb_sel   <= '0;
      illegal  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        eff_addr <= c_eff;
        wb_data  <= c_wb;
        wb_en    <= c_wb_en;
        wb_sel   <= ptr_sel;
        illegal  <= c_bad;
      end else begin
        wb_en   <= 1'b0;
        illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/agu_ptr_unit_chk.sv
module agu_ptr_unit_chk #(
  parameter int DW    = 8,
  parameter int DISPW = 6,
  localparam int AW   = 2 * DW
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       mode,
  input logic [AW-1:0]    direct_addr,
  input logic             done,
  input logic [AW-1:0]    eff_addr,
  input logic [AW-1:0]    wb_data,
  input logic             wb_en,
  input logic             illegal
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R2
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done); // R2
  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done); // R10
  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wb_en && eff_addr == '0)); // R9
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (rst)
    (wb_en && $past(mode) == agu_pkg::AM_PREDEC) |-> (eff_addr == wb_data)); // R6
  AST_POSTINC_NEXT: assert property (@(posedge clk) disable iff (rst)
    (wb_en && $past(mode) == agu_pkg::AM_POSTINC) |-> (wb_data == eff_addr + 1'b1)); // R7
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (start && mode == agu_pkg::AM_DIRECT) |=> (eff_addr == $past(direct_addr) && !wb_en)); // R4
endmodule

bind agu_ptr_unit agu_ptr_unit_chk #(.DW(DW), .DISPW(DISPW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .mode        (mode),
  .direct_addr (direct_addr),
  .done        (done),
  .eff_addr    (eff_addr),
  .wb_data     (wb_data),
  .wb_en       (wb_en),
  .illegal     (illegal)
);

// File: tb/agu_ptr_unit_test.sv
module agu_ptr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst;
  logic        start;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic [5:0]  disp;
  logic [15:0] direct_addr;
  logic [47:0] gpr_hi;
  logic        done;
  logic [15:0] eff_addr;
  logic [15:0] wb_data;
  logic        wb_en;
  logic [1:0]  wb_sel;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_ptr_unit uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ptr_sel(ptr_sel),
    .disp(disp), .direct_addr(direct_addr), .gpr_hi(gpr_hi),
    .done(done), .eff_addr(eff_addr), .wb_data(wb_data), .wb_en(wb_en),
    .wb_sel(wb_sel), .illegal(illegal)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ptr_of(input logic [47:0] g, input int s);
    return {g[(2*s+1)*8 +: 8], g[(2*s)*8 +: 8]};
  endfunction

  task automatic run_one(input int m, input int s, input logic [15:0] pv,
                         input logic [5:0] d);
    logic [15:0] p;
    logic [15:0] e_eff, e_wb;
    logic        e_en, e_bad;
    string       tag;
    // fill all three pointers with distinct values, selected one equals pv
    @(negedge clk);
    gpr_hi      = {pv ^ 16'h5A5A, pv ^ 16'hA5A5, pv ^ 16'h0F0F};
    if (s < 3) gpr_hi[s*16 +: 16] = pv;
    mode        = m[2:0];
    ptr_sel     = s[1:0];
    disp        = d;
    direct_addr = pv ^ 16'h3C3C;
    start       = 1'b1;
    p     = (s < 3) ? ptr_of(gpr_hi, s) : 16'h0;
    e_eff = 16'h0; e_wb = 16'h0; e_en = 1'b0;
    e_bad = (m > 4) || (m >= 1 && m <= 4 && s == 3) || (m == 2 && s == 0);
    tag = "R9";
    if (!e_bad) begin
      case (m)
        0: begin e_eff = direct_addr; tag = "R4"; end
        1: begin e_eff = p; tag = "R3"; end
        2: begin e_eff = 16'((32'(p) + 32'(d)) % 65536); tag = (32'(p) + 32'(d) > 65535) ? "R8" : "R5"; end
        3: begin e_eff = 16'((32'(p) + 65535) % 65536); e_wb = e_eff; e_en = 1'b1;
                 tag = (p == 16'h0) ? "R8" : "R6"; end
        default: begin e_eff = p; e_wb = 16'((32'(p) + 1) % 65536); e_en = 1'b1;
                 tag = (p == 16'hFFFF) ? "R8" : "R7"; end
      endcase
    end
    @(negedge clk);
    start = 1'b0;
    check(tag, {done, e_bad ? 1'b1 : illegal, eff_addr, wb_data, wb_en, 3'b0, e_en ? wb_sel : 2'b0},
               {1'b1, e_bad ? 1'b1 : 1'b0, e_eff, e_wb, e_en, 3'b0, e_en ? s[1:0] : 2'b0});
    if (e_bad) check("R9", {39'h0, illegal}, 40'h1);
    @(negedge clk);
    check("R10", {38'h0, done, wb_en}, 40'h0);
  endtask

  initial begin
    logic [15:0] pvals [5];
    logic [5:0]  dvals [4];
    pvals = '{16'h0000, 16'hFFFF, 16'h1234, 16'h00FF, 16'hFFC8};
    dvals = '{6'd0, 6'd1, 6'd63, 6'd42};
    rst = 1'b1; start = 0; mode = 0; ptr_sel = 0; disp = 0;
    direct_addr = 0; gpr_hi = 0;
    repeat (3) @(negedge clk);
    check("R1", {done, wb_en, illegal, eff_addr, wb_data, wb_sel},
                40'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {done, wb_en, illegal, eff_addr, wb_data, wb_sel}, 40'h0);
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int pi = 0; pi < 5; pi++)
          for (int di = 0; di < 4; di++)
            run_one(m, s, pvals[pi], dvals[di]);
    // idle cycles: no done, no writeback (R2, R10)
    repeat (4) begin
      @(negedge clk);
      check("R2", {38'h0, done, wb_en}, 40'h0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule